// File: doc/BRIEF.md
# SDRAM Presence-Detect Configuration Parser

This block listens to the opening 64 bytes of a memory module's presence-detect EEPROM and turns them into the settings a memory controller needs. Each byte arrives with a valid strobe and its index. The parser keeps the handful of bytes that describe the module and adds every byte to an 8-bit running sum. When the byte with index 63 arrives, it commits a complete configuration in one step. The configuration holds the clamped row and column address counts, the log2 of the internal bank count, the number of chip selects, the chosen CAS latency, the refresh tick count and the log2 of one side's total size. A set of warning flags comes with it.

A `start_i` pulse begins each new readout. It throws away everything gathered so far and returns the outputs to their defaults. The EEPROM transport is outside the block, and so is the assembly of controller register words. A static input picks one of two CAS-latency policies: optimistic takes the lowest supported latency, pessimistic takes the highest.

Top module: `spd_cfg_parser`

## Requirements
- R1: After reset, and until a byte with index 63 is committed, the outputs are: rows 0, columns 0, bank log2 0, chip selects 1, CAS latency 3, refresh ticks 14, size log2 0, every warning 0, done 0. The outputs do not change in any cycle other than a commit or a start.
- R2: A byte with index 63 that is accepted at a clock edge (valid high, start low) updates all configuration outputs at that same edge. `done_o` is high for exactly the following cycle.
- R3: The chip-select count is bits [3:0] of byte 5.
- R4: The data width is byte 6 + 256 × byte 7. `warn_width_o` is set when the width is neither 64 nor 72, and the size calculation still assumes 8-byte words.
- R5: Bits [6:0] of byte 12 select the refresh ticks: code 0→14, 1→2, 2→6, 3→29, 4→60, 5→120, and any other code→14.
- R6: Byte 17 gives the bank count. The value 2 gives log2 1, 4 gives 2, 8 gives 3, and any other value gives 0.
- R7: Byte 18 is a latency mask. With `cl_pessim_i`=0, bit 0 gives CL1, otherwise bit 1 gives CL2, otherwise bit 2 gives CL3. With `cl_pessim_i`=1, bit 2 is tested first, then bit 1, then bit 0.
- R8: If none of mask bits [2:0] is set, the CAS latency is 3 and `warn_cl_unk_o` is set. A selected CL1 is output as 2 with `warn_cl_low_o` set. The output latency is never below 2.
- R9: Rows are bits [3:0] of byte 3 and columns are bits [3:0] of byte 4. Rows above 14 become 14 with `warn_rows_o` set. Columns above 11 become 11 with `warn_cols_o` set.
- R10: The 8-bit wrapping sum of the bytes with indices 0 to 62 is compared with byte 63. A mismatch sets `warn_csum_o`.
- R11: Size log2 = clamped rows + clamped columns + bank log2 + 3.
- R12: A byte with index above 63, or any data without valid, changes neither the collected fields, the sum nor the outputs.
- R13: `start_i` clears the sum, the collected bytes and every flag, and returns the outputs to the R1 defaults at the next edge. A byte presented in the same cycle as `start_i` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new readout, clearing all state |
| cl_pessim_i | input | 1 | CAS-latency policy: 0 picks the lowest latency, 1 picks the highest |
| byte_vld_i | input | 1 | Byte strobe |
| byte_idx_i | input | 8 | Byte index within the EEPROM |
| byte_dat_i | input | 8 | Byte value |
| rows_o | output | 4 | Clamped row address count |
| cols_o | output | 4 | Clamped column address count |
| bank_l2_o | output | 2 | log2 of internal bank count |
| cs_cnt_o | output | 4 | Chip-select count |
| cas_lat_o | output | 2 | Chosen CAS latency |
| refresh_o | output | 7 | Refresh ticks (about 1 us each) |
| size_l2_o | output | 6 | log2 of one side's size in bytes |
| done_o | output | 1 | One-cycle pulse after commit |
| warn_width_o | output | 1 | Data width not 64 or 72 |
| warn_cl_unk_o | output | 1 | No supported latency bit |
| warn_cl_low_o | output | 1 | CL1 was raised to 2 |
| warn_rows_o | output | 1 | Rows were clamped |
| warn_cols_o | output | 1 | Columns were clamped |
| warn_csum_o | output | 1 | Checksum mismatch |

## Verification
The assertions watch several properties on every cycle. They check that the done pulse follows an accepted index-63 byte and nothing else, and that the latency never drops below 2. They check that rows and columns stay inside their clamps and that the committed size matches its parts. They also check that a start restores the defaults and that the outputs hold steady between events. Only the bench's scenarios can show the actual mappings: the refresh translation, the bank conversion, the two latency priorities, the checksum verdict, and the dropping of out-of-range indices and of bytes that collide with a start. These need known EEPROM images and a reference model to compare against.

// File: rtl/spd_pkg.sv
// Shared types and tables for the presence-detect parser.
// Assumes 8-bit EEPROM bytes and a 64-byte checksummed region.
package spd_pkg;

    localparam int unsigned SPD_NIB_W  = 4;
    localparam int unsigned SPD_BL2_W  = 2;
    localparam int unsigned SPD_CL_W   = 2;
    localparam int unsigned SPD_REF_W  = 7;
    localparam int unsigned SPD_SIZE_W = 6;

    // Slots of the captured-byte array, and the EEPROM index each one stores
    localparam int unsigned SPD_CAP_N = 8;
    localparam int unsigned SLOT_ROWS  = 0;
    localparam int unsigned SLOT_COLS  = 1;
    localparam int unsigned SLOT_CS    = 2;
    localparam int unsigned SLOT_WLO   = 3;
    localparam int unsigned SLOT_WHI   = 4;
    localparam int unsigned SLOT_REF   = 5;
    localparam int unsigned SLOT_BANKS = 6;
    localparam int unsigned SLOT_CLMSK = 7;
    localparam int unsigned SPD_CAP_IDX [SPD_CAP_N] = '{3, 4, 5, 6, 7, 12, 17, 18};

    typedef struct packed {
        logic [SPD_NIB_W-1:0]  rows;
        logic [SPD_NIB_W-1:0]  cols;
        logic [SPD_BL2_W-1:0]  bank_l2;
        logic [SPD_NIB_W-1:0]  cs_cnt;
        logic [SPD_CL_W-1:0]   cas_lat;
        logic [SPD_REF_W-1:0]  refresh;
        logic [SPD_SIZE_W-1:0] size_l2;
        logic                  w_width;
        logic                  w_cl_unk;
        logic                  w_cl_low;
        logic                  w_rows;
        logic                  w_cols;
        logic                  w_csum;
    } spd_cfg_t;

    localparam spd_cfg_t SPD_CFG_DFLT = '{
        rows: '0, cols: '0, bank_l2: '0, cs_cnt: SPD_NIB_W'(1),
        cas_lat: SPD_CL_W'(3), refresh: SPD_REF_W'(14), size_l2: '0,
        w_width: 1'b0, w_cl_unk: 1'b0, w_cl_low: 1'b0,
        w_rows: 1'b0, w_cols: 1'b0, w_csum: 1'b0
    };

    // Translate the refresh period code into microsecond ticks
    function automatic logic [SPD_REF_W-1:0] refresh_ticks(input logic [6:0] code);
        case (code)
            7'd1:    return SPD_REF_W'(2);
            7'd2:    return SPD_REF_W'(6);
            7'd3:    return SPD_REF_W'(29);
            7'd4:    return SPD_REF_W'(60);
            7'd5:    return SPD_REF_W'(120);
            default: return SPD_REF_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/spd_field_capture.sv
// Captures the EEPROM bytes the decoder needs, one register per slot.
// Assumes a byte index outside the slot list never matches (indices are
// compared at full width, so indices above 63 cannot alias).
module spd_field_capture
    import spd_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned DAT_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr,
    input  logic                              en,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [DAT_W-1:0]                  dat,
    output logic [SPD_CAP_N-1:0][DAT_W-1:0]   cap
);
    for (genvar g = 0; g < SPD_CAP_N; g++) begin : g_slot
        // Store the byte whose index matches this slot
        always_ff @(posedge clk) begin
            if (!rst_n || clr)
                cap[g] <= '0;
            else if (en && idx == IDX_W'(SPD_CAP_IDX[g]))
                cap[g] <= dat;
        end
    end
endmodule

// File: rtl/spd_csum_acc.sv
// Running 8-bit checksum over bytes with indices below LAST_IDX.
// Assumes each index is delivered once per readout, in any order before LAST_IDX.
module spd_csum_acc #(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned DAT_W    = 8,
    parameter int unsigned LAST_IDX = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DAT_W-1:0] dat,
    output logic             mismatch
);
    logic [DAT_W-1:0] acc_q;

    // Accumulate the bytes that are part of the checksummed region
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            acc_q <= '0;
        else if (en && idx < IDX_W'(LAST_IDX))
            acc_q <= acc_q + dat;
    end

    // Compare against the byte now on the bus (meaningful when it is the last one)
    always_comb mismatch = (acc_q != dat);
endmodule

// File: rtl/spd_cfg_decode.sv
// Combinational decode of captured bytes into a configuration record.
// Applies clamps, the refresh table, the bank conversion and the CL policy.
module spd_cfg_decode
    import spd_pkg::*;
#(
    parameter int unsigned DAT_W    = 8,
    parameter int unsigned ROW_MAX  = 14,
    parameter int unsigned COL_MAX  = 11,
    parameter int unsigned BUS_L2   = 3,
    parameter int unsigned WIDTH_A  = 64,
    parameter int unsigned WIDTH_B  = 72
) (
    input  logic [SPD_CAP_N-1:0][DAT_W-1:0] cap,
    input  logic                            pessim,
    input  logic                            csum_bad,
    output spd_cfg_t                        cfg
);
    localparam int unsigned WID_W = 2 * DAT_W;

    logic [SPD_NIB_W-1:0] rows_raw, cols_raw;
    logic [WID_W-1:0]     width;
    logic [DAT_W-1:0]     banks, clmask;
    logic [SPD_CL_W-1:0]  cl_pick;
    logic                 cl_none;
    logic                 unused_hi;

    // Pull raw fields out of the captured slots
    always_comb begin
        rows_raw = cap[SLOT_ROWS][SPD_NIB_W-1:0];
        cols_raw = cap[SLOT_COLS][SPD_NIB_W-1:0];
        width    = {cap[SLOT_WHI], cap[SLOT_WLO]};
        banks    = cap[SLOT_BANKS];
        clmask   = cap[SLOT_CLMSK];
    end

    assign unused_hi = ^{cap[SLOT_ROWS][DAT_W-1:SPD_NIB_W], cap[SLOT_COLS][DAT_W-1:SPD_NIB_W],
                         cap[SLOT_CS][DAT_W-1:SPD_NIB_W], cap[SLOT_REF][DAT_W-1],
                         clmask[DAT_W-1:3]};

    // Pick the CAS latency under the chosen priority
    always_comb begin
        cl_none = 1'b0;
        cl_pick = SPD_CL_W'(3);
        if (!pessim) begin
            if (clmask[0])      cl_pick = SPD_CL_W'(1);
            else if (clmask[1]) cl_pick = SPD_CL_W'(2);
            else if (clmask[2]) cl_pick = SPD_CL_W'(3);
            else                cl_none = 1'b1;
        end else begin
            if (clmask[2])      cl_pick = SPD_CL_W'(3);
            else if (clmask[1]) cl_pick = SPD_CL_W'(2);
            else if (clmask[0]) cl_pick = SPD_CL_W'(1);
            else                cl_none = 1'b1;
        end
    end

    // Assemble the clamped configuration and warnings
    always_comb begin
        cfg = SPD_CFG_DFLT;
        cfg.w_rows = (rows_raw > SPD_NIB_W'(ROW_MAX));
        cfg.rows   = cfg.w_rows ? SPD_NIB_W'(ROW_MAX) : rows_raw;
        cfg.w_cols = (cols_raw > SPD_NIB_W'(COL_MAX));
        cfg.cols   = cfg.w_cols ? SPD_NIB_W'(COL_MAX) : cols_raw;
        cfg.cs_cnt = cap[SLOT_CS][SPD_NIB_W-1:0];
        cfg.w_width = (width != WID_W'(WIDTH_A)) && (width != WID_W'(WIDTH_B));
        cfg.refresh = refresh_ticks(cap[SLOT_REF][6:0]);
        case (banks)
            DAT_W'(2): cfg.bank_l2 = SPD_BL2_W'(1);
            DAT_W'(4): cfg.bank_l2 = SPD_BL2_W'(2);
            DAT_W'(8): cfg.bank_l2 = SPD_BL2_W'(3);
            default:   cfg.bank_l2 = '0;
        endcase
        cfg.w_cl_unk = cl_none;
        cfg.w_cl_low = (cl_pick < SPD_CL_W'(2));
        cfg.cas_lat  = cfg.w_cl_low ? SPD_CL_W'(2) : cl_pick;
        cfg.size_l2  = SPD_SIZE_W'(cfg.rows) + SPD_SIZE_W'(cfg.cols)
                     + SPD_SIZE_W'(cfg.bank_l2) + SPD_SIZE_W'(BUS_L2);
        cfg.w_csum   = csum_bad;
    end
endmodule

// File: rtl/spd_cfg_parser.sv
// Top of the presence-detect parser: gathers bytes, sums them and commits a
// decoded configuration when the last checksummed byte arrives.
// Assumes one readout per start pulse; start has priority over a byte.
module spd_cfg_parser
    import spd_pkg::*;
#(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned DAT_W    = 8,
    parameter int unsigned LAST_IDX = 63,
    parameter int unsigned ROW_MAX  = 14,
    parameter int unsigned COL_MAX  = 11,
    parameter int unsigned BUS_L2   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  cl_pessim_i,
    input  logic                  byte_vld_i,
    input  logic [IDX_W-1:0]      byte_idx_i,
    input  logic [DAT_W-1:0]      byte_dat_i,
    output logic [SPD_NIB_W-1:0]  rows_o,
    output logic [SPD_NIB_W-1:0]  cols_o,
    output logic [SPD_BL2_W-1:0]  bank_l2_o,
    output logic [SPD_NIB_W-1:0]  cs_cnt_o,
    output logic [SPD_CL_W-1:0]   cas_lat_o,
    output logic [SPD_REF_W-1:0]  refresh_o,
    output logic [SPD_SIZE_W-1:0] size_l2_o,
    output logic                  done_o,
    output logic                  warn_width_o,
    output logic                  warn_cl_unk_o,
    output logic                  warn_cl_low_o,
    output logic                  warn_rows_o,
    output logic                  warn_cols_o,
    output logic                  warn_csum_o
);
    logic                           take, commit, csum_bad;
    logic [SPD_CAP_N-1:0][DAT_W-1:0] cap;
    spd_cfg_t                       cfg_d, cfg_q;
    logic                           done_q;

    // A byte is taken only when no start competes with it
    always_comb begin
        take   = byte_vld_i && !start_i;
        commit = take && (byte_idx_i == IDX_W'(LAST_IDX));
    end

    spd_field_capture #(.IDX_W(IDX_W), .DAT_W(DAT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(start_i), .en(take),
        .idx(byte_idx_i), .dat(byte_dat_i), .cap(cap)
    );

    spd_csum_acc #(.IDX_W(IDX_W), .DAT_W(DAT_W), .LAST_IDX(LAST_IDX)) u_sum (
        .clk(clk), .rst_n(rst_n), .clr(start_i), .en(take),
        .idx(byte_idx_i), .dat(byte_dat_i), .mismatch(csum_bad)
    );

    spd_cfg_decode #(.DAT_W(DAT_W), .ROW_MAX(ROW_MAX), .COL_MAX(COL_MAX),
                     .BUS_L2(BUS_L2)) u_dec (
        .cap(cap), .pessim(cl_pessim_i), .csum_bad(csum_bad), .cfg(cfg_d)
    );

    // Hold defaults until commit; restart restores them
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            cfg_q  <= SPD_CFG_DFLT;
            done_q <= 1'b0;
        end else begin
            done_q <= commit;
            if (commit)
                cfg_q <= cfg_d;
        end
    end

    // Drive the ports from the committed record
    always_comb begin
        rows_o        = cfg_q.rows;
        cols_o        = cfg_q.cols;
        bank_l2_o     = cfg_q.bank_l2;
        cs_cnt_o      = cfg_q.cs_cnt;
        cas_lat_o     = cfg_q.cas_lat;
        refresh_o     = cfg_q.refresh;
        size_l2_o     = cfg_q.size_l2;
        done_o        = done_q;
        warn_width_o  = cfg_q.w_width;
        warn_cl_unk_o = cfg_q.w_cl_unk;
        warn_cl_low_o = cfg_q.w_cl_low;
        warn_rows_o   = cfg_q.w_rows;
        warn_cols_o   = cfg_q.w_cols;
        warn_csum_o   = cfg_q.w_csum;
    end
endmodule

// File: rtl/spd_cfg_parser_chk.sv
// Checker for spd_cfg_parser, attached by bind. Observes ports only.
module spd_cfg_parser_chk #(
    parameter int unsigned IDX_W    = 8,
    parameter int unsigned LAST_IDX = 63,
    parameter int unsigned ROW_MAX  = 14,
    parameter int unsigned COL_MAX  = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             byte_vld_i,
    input logic [IDX_W-1:0] byte_idx_i,
    input logic [3:0]       rows_o,
    input logic [3:0]       cols_o,
    input logic [1:0]       bank_l2_o,
    input logic [3:0]       cs_cnt_o,
    input logic [1:0]       cas_lat_o,
    input logic [6:0]       refresh_o,
    input logic [5:0]       size_l2_o,
    input logic             done_o,
    input logic             warn_width_o,
    input logic             warn_cl_unk_o,
    input logic             warn_cl_low_o,
    input logic             warn_rows_o,
    input logic             warn_cols_o,
    input logic             warn_csum_o
);
    logic last_take;
    logic [5:0] warns;
    always_comb begin
        last_take = byte_vld_i && !start_i && (byte_idx_i == IDX_W'(LAST_IDX));
        warns = {warn_width_o, warn_cl_unk_o, warn_cl_low_o, warn_rows_o, warn_cols_o, warn_csum_o};
    end

    a_r2_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(last_take)) |-> done_o);

    a_r2_done_only_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(rst_n) && $past(last_take)));

    a_r8_cl_floor: assert property (@(posedge clk) disable iff (!rst_n)
        cas_lat_o >= 2'd2);

    a_r9_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (rows_o <= 4'(ROW_MAX)) && (cols_o <= 4'(COL_MAX)));

    a_r11_size_sum: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (size_l2_o == 6'(rows_o) + 6'(cols_o) + 6'(bank_l2_o) + 6'd3));

    a_r13_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(start_i)) |->
        (!done_o && warns == 6'd0 && cs_cnt_o == 4'd1 && cas_lat_o == 2'd3 && refresh_o == 7'd14));

    a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(start_i) && !$past(last_take)) |->
        $stable({rows_o, cols_o, bank_l2_o, cs_cnt_o, cas_lat_o, refresh_o, size_l2_o, warns}));
endmodule

bind spd_cfg_parser spd_cfg_parser_chk #(
    .IDX_W(IDX_W), .LAST_IDX(LAST_IDX), .ROW_MAX(ROW_MAX), .COL_MAX(COL_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_vld_i(byte_vld_i),
    .byte_idx_i(byte_idx_i), .rows_o(rows_o), .cols_o(cols_o), .bank_l2_o(bank_l2_o),
    .cs_cnt_o(cs_cnt_o), .cas_lat_o(cas_lat_o), .refresh_o(refresh_o),
    .size_l2_o(size_l2_o), .done_o(done_o), .warn_width_o(warn_width_o),
    .warn_cl_unk_o(warn_cl_unk_o), .warn_cl_low_o(warn_cl_low_o),
    .warn_rows_o(warn_rows_o), .warn_cols_o(warn_cols_o), .warn_csum_o(warn_csum_o)
);

// File: tb/spd_cfg_parser_tb_top.sv
// Bench: behavioural reference model compared with the outputs every cycle,
// plus directed checks for defaults, ignored bytes and restart.
module spd_cfg_parser_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cl_pessim_i = 1'b0;
    logic       byte_vld_i = 1'b0;
    logic [7:0] byte_idx_i = '0;
    logic [7:0] byte_dat_i = '0;
    logic [3:0] rows_o, cols_o, cs_cnt_o;
    logic [1:0] bank_l2_o, cas_lat_o;
    logic [6:0] refresh_o;
    logic [5:0] size_l2_o;
    logic done_o, warn_width_o, warn_cl_unk_o, warn_cl_low_o, warn_rows_o, warn_cols_o, warn_csum_o;

    always #10 clk = ~clk;   // 50 MHz

    spd_cfg_parser dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cl_pessim_i(cl_pessim_i),
        .byte_vld_i(byte_vld_i), .byte_idx_i(byte_idx_i), .byte_dat_i(byte_dat_i),
        .rows_o(rows_o), .cols_o(cols_o), .bank_l2_o(bank_l2_o), .cs_cnt_o(cs_cnt_o),
        .cas_lat_o(cas_lat_o), .refresh_o(refresh_o), .size_l2_o(size_l2_o),
        .done_o(done_o), .warn_width_o(warn_width_o), .warn_cl_unk_o(warn_cl_unk_o),
        .warn_cl_low_o(warn_cl_low_o), .warn_rows_o(warn_rows_o),
        .warn_cols_o(warn_cols_o), .warn_csum_o(warn_csum_o)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int mem [64];
    int e_rows, e_cols, e_bank, e_cs, e_cl, e_ref, e_size, e_done;
    int e_ww, e_wu, e_wl, e_wr, e_wc, e_ws;

    task automatic model_defaults();
        e_rows = 0; e_cols = 0; e_bank = 0; e_cs = 1; e_cl = 3; e_ref = 14; e_size = 0;
        e_ww = 0; e_wu = 0; e_wl = 0; e_wr = 0; e_wc = 0; e_ws = 0;
        for (int i = 0; i < 64; i++) mem[i] = 0;
    endtask

    task automatic model_commit(input bit pess);
        int r, c, w, code, b, m, cl, sum;
        r = mem[3] & 15; e_wr = (r > 14); if (e_wr) r = 14;
        c = mem[4] & 15; e_wc = (c > 11); if (e_wc) c = 11;
        e_rows = r; e_cols = c; e_cs = mem[5] & 15;
        w = mem[6] + mem[7] * 256; e_ww = (w != 64 && w != 72);
        code = mem[12] & 127;
        case (code) 1: e_ref = 2; 2: e_ref = 6; 3: e_ref = 29; 4: e_ref = 60; 5: e_ref = 120; default: e_ref = 14; endcase
        b = mem[17];
        e_bank = (b == 2) ? 1 : (b == 4) ? 2 : (b == 8) ? 3 : 0;
        m = mem[18]; e_wu = 0; cl = 3;
        if (!pess) begin
            if (m & 1) cl = 1; else if (m & 2) cl = 2; else if (m & 4) cl = 3; else e_wu = 1;
        end else begin
            if (m & 4) cl = 3; else if (m & 2) cl = 2; else if (m & 1) cl = 1; else e_wu = 1;
        end
        e_wl = (cl < 2); e_cl = e_wl ? 2 : cl;
        sum = 0;
        for (int i = 0; i < 63; i++) sum = (sum + mem[i]) & 255;
        e_ws = (sum != mem[63]);
        e_size = r + c + e_bank + 3;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_defaults(); e_done = 0;
        end else begin
            e_done = 0;
            if (start_i) model_defaults();
            else if (byte_vld_i) begin
                if (byte_idx_i < 64) mem[byte_idx_i] = int'(byte_dat_i);
                if (byte_idx_i == 63) begin model_commit(cl_pessim_i); e_done = 1; end
            end
        end
    end

    // Compare every output against the model each cycle, away from the edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R9",  "rows",      int'(rows_o),      e_rows);
            check("R9",  "cols",      int'(cols_o),      e_cols);
            check("R3",  "cs_cnt",    int'(cs_cnt_o),    e_cs);
            check("R6",  "bank_l2",   int'(bank_l2_o),   e_bank);
            check("R7",  "cas_lat",   int'(cas_lat_o),   e_cl);
            check("R5",  "refresh",   int'(refresh_o),   e_ref);
            check("R11", "size_l2",   int'(size_l2_o),   e_size);
            check("R2",  "done",      int'(done_o),      e_done);
            check("R4",  "warn_width", int'(warn_width_o), e_ww);
            check("R8",  "warn_cl_unk", int'(warn_cl_unk_o), e_wu);
            check("R8",  "warn_cl_low", int'(warn_cl_low_o), e_wl);
            check("R9",  "warn_rows", int'(warn_rows_o), e_wr);
            check("R9",  "warn_cols", int'(warn_cols_o), e_wc);
            check("R10", "warn_csum", int'(warn_csum_o), e_ws);
        end
    end

    // ---------------- stimulus ----------------
    task automatic put(input int idx, input int dat);
        @(negedge clk);
        byte_vld_i = 1'b1; byte_idx_i = 8'(idx); byte_dat_i = 8'(dat);
        @(negedge clk);
        byte_vld_i = 1'b0; byte_dat_i = 8'hA5;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic run_image(input int r, input int c, input int cs, input int w,
                             input int code, input int bk, input int clm, input bit pess,
                             input bit bad_sum, input bit junk, input int seed);
        int img [64];
        int sum;
        for (int i = 0; i < 64; i++) img[i] = (i * 37 + seed) & 255;
        img[3] = r; img[4] = c; img[5] = cs; img[6] = w & 255; img[7] = (w >> 8) & 255;
        img[12] = code; img[17] = bk; img[18] = clm;
        sum = 0;
        for (int i = 0; i < 63; i++) sum = (sum + img[i]) & 255;
        img[63] = bad_sum ? (sum ^ 1) : sum;
        cl_pessim_i = pess;
        pulse_start();
        for (int i = 0; i < 64; i++) begin
            put(i, img[i]);
            if (junk && i == 3) begin
                put(67, 8'h0F);      // R12: index above 63 must not touch anything
                put(200, 8'hFF);
                @(negedge clk); byte_idx_i = 8'd63; byte_dat_i = 8'h00; // no valid
            end
            repeat (i % 3) @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        model_defaults(); e_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: defaults after reset
        check("R1", "reset rows", int'(rows_o), 0);
        check("R1", "reset cs", int'(cs_cnt_o), 1);
        check("R1", "reset cl", int'(cas_lat_o), 3);
        check("R1", "reset refresh", int'(refresh_o), 14);
        check("R1", "reset done", int'(done_o), 0);

        // Main images: refresh codes, banks, CL policies, widths
        run_image(12, 9, 2, 64, 8'h82, 4, 8'h06, 1'b0, 1'b0, 1'b0, 11);
        check("R7", "optimistic mask 6", int'(cas_lat_o), 2);
        run_image(12, 9, 2, 64, 8'h82, 4, 8'h06, 1'b1, 1'b0, 1'b0, 12);
        check("R7", "pessimistic mask 6", int'(cas_lat_o), 3);
        run_image(13, 10, 1, 72, 0, 8, 8'h07, 1'b0, 1'b0, 1'b0, 13);
        check("R8", "CL1 raised", int'(cas_lat_o), 2);
        check("R8", "CL1 warn", int'(warn_cl_low_o), 1);
        run_image(13, 10, 1, 72, 1, 2, 8'h07, 1'b1, 1'b0, 1'b0, 14);
        run_image(11, 8, 4, 80, 3, 3, 8'h00, 1'b0, 1'b0, 1'b0, 15);
        check("R8", "no CL bit", int'(warn_cl_unk_o), 1);
        check("R4", "width 80", int'(warn_width_o), 1);
        run_image(15, 13, 2, 64, 4, 4, 8'h01, 1'b1, 1'b0, 1'b0, 16);
        check("R9", "rows clamp", int'(rows_o), 14);
        check("R9", "cols clamp", int'(cols_o), 11);
        check("R11", "size clamp", int'(size_l2_o), 30);
        run_image(12, 10, 2, 64, 5, 4, 8'h02, 1'b0, 1'b1, 1'b0, 17);
        check("R10", "bad checksum", int'(warn_csum_o), 1);
        run_image(12, 10, 2, 64, 6, 1, 8'h04, 1'b0, 1'b0, 1'b0, 18);
        check("R5", "code 6", int'(refresh_o), 14);
        check("R10", "good checksum", int'(warn_csum_o), 0);
        run_image(12, 10, 2, 64, 7, 4, 8'h04, 1'b0, 1'b0, 1'b1, 19);
        check("R12", "junk indices ignored rows", int'(rows_o), 12);
        check("R12", "junk indices ignored csum", int'(warn_csum_o), 0);

        // R13: start clears, and a byte alongside start is dropped
        @(negedge clk);
        start_i = 1'b1; byte_vld_i = 1'b1; byte_idx_i = 8'd63; byte_dat_i = 8'h00;
        @(negedge clk);
        start_i = 1'b0; byte_vld_i = 1'b0;
        check("R13", "no done with start", int'(done_o), 0);
        check("R13", "cs default", int'(cs_cnt_o), 1);
        check("R13", "rows default", int'(rows_o), 0);
        repeat (3) @(negedge clk);
        check("R1", "hold after start", int'(refresh_o), 14);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule